// File: doc/BRIEF.md
# Time-of-Day Clock with Action-Coded Access and Fractional Trim

This block keeps a running time of day for precision time stamping: a 48-bit seconds count and a nanoseconds count that rolls over at one billion. While the global run bit is set, every clock cycle adds a fixed nominal period (a parameter, in nanoseconds) to the nanoseconds count. When the count reaches one billion it wraps and carries into the seconds. The live time is also driven on output ports, so that nearby time stampers can sample it.

Software reaches the block through a small register window. Three shadow registers hold a seconds upper part, a seconds lower part and a nanoseconds word. Software writes an action code into an access control word. That code either copies the live time into the shadows (snapshot), copies the shadows into the live time (load), or adds the signed nanoseconds shadow to the live time (step). A trim unit counts elapsed time against a programmable interval, in picoseconds or nanoseconds. Each time the interval runs out, it inserts one extra nanosecond into that cycle's advance, or removes one.

Top module: `tod_clock`

## Requirements
- R1: After reset the live time (`todSec`, `todNs`) is zero, and every readable register reads zero.
- R2: While bit 2 of the run register (offset 0xA0) is set, each cycle adds NOM_NS to `todNs`. On reaching 1,000,000,000 the count wraps to the remainder and `todSec` increments by one. Counting begins on the cycle after the write that sets the bit, and the last counted edge is the edge of the write that clears it.
- R3: While the run bit is clear, the live time holds. The other bits of the run register have no effect on counting.
- R4: Action code 2 (bits 5:3 of the access word at offset 0x00) is a snapshot. It loads the seconds upper shadow (offset 0x04, bits 15:0), the seconds lower shadow (0x08) and the nanoseconds shadow (0x0C) with the live time present just before the write edge. It does not disturb the live time, even while counting.
- R5: Action code 1 is a load. On the write edge the live time takes {0x04[15:0], 0x08} seconds and 0x0C[29:0] nanoseconds, and no period is added on that edge.
- R6: Action code 4 is a step. On the write edge the live time moves by the nanoseconds shadow, read as a signed 32-bit value, with one borrow from or carry into the seconds. No period is added on that edge. The magnitude must stay below one second.
- R7: Action codes 0, 3, 5, 6 and 7 change neither the live time nor the shadow registers.
- R8: The access word reads back bit 0 (domain), bit 2 (sync) and bits 5:3 (action) as last written. Its other bits read zero.
- R9: Trim is configured in two registers. At offset 0xA4, bit 0 enables trim and bit 1 selects direction (1 removes a nanosecond, 0 adds one). At offset 0xA8, bits 29:0 hold the interval and bit 30 selects nanosecond units instead of picosecond units. Each counted cycle advances an accumulator by NOM_NS×1000 (picosecond units) or by NOM_NS (nanosecond units). After n counted cycles from a cleared accumulator, exactly floor(n·step/interval) corrections have been applied, provided the interval exceeds one step.
- R10: When a correction and a nanoseconds wrap fall on the same edge, the seconds still advance by exactly one and the remainder includes the correction.
- R11: With trim disabled, or with an interval of zero, no correction is applied and the accumulator is cleared.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| regWrEn | input | 1 | Register write strobe |
| regAddr | input | 8 | Register byte offset |
| regWrData | input | 32 | Write data |
| regRdData | output | 32 | Read data for `regAddr` (combinational) |
| todSec | output | 48 | Live seconds |
| todNs | output | 30 | Live nanoseconds |

## Verification
The two functions that can coincide are a trim correction and a nanoseconds wrap. The bench provokes this directly by loading a time nine nanoseconds short of a second, with a nanosecond-unit interval of nine. With that setup the second counted edge carries both the extra nanosecond and the rollover. Randomly drawn runs then start close to the one-second boundary with random intervals, directions and lengths. Each result is judged against a closed-form expectation: counted cycles times the period, plus or minus floor(n·step/interval), normalised once into seconds.

// File: rtl/tod_pkg.sv
package tod_pkg;

  localparam int unsigned NS_PER_SEC = 1_000_000_000;

  // byte offsets of the register window
  localparam logic [7:0] OFF_ACCESS   = 8'h00;
  localparam logic [7:0] OFF_SEC_HI   = 8'h04;
  localparam logic [7:0] OFF_SEC_LO   = 8'h08;
  localparam logic [7:0] OFF_NSEC     = 8'h0C;
  localparam logic [7:0] OFF_RUN      = 8'hA0;
  localparam logic [7:0] OFF_TRIM_CFG = 8'hA4;
  localparam logic [7:0] OFF_TRIM_IVL = 8'hA8;

  typedef enum logic [2:0] {
    ACT_IDLE   = 3'd0,
    ACT_LOAD   = 3'd1,
    ACT_SAVE   = 3'd2,
    ACT_CLOCK  = 3'd3,
    ACT_STEP   = 3'd4,
    ACT_NOSYNC = 3'd5,
    ACT_SYNC   = 3'd6
  } todAction_e;

  typedef struct packed {
    logic tick;      // add the nominal period this cycle
    logic corrUp;    // add one extra nanosecond
    logic corrDown;  // remove one nanosecond
    logic load;      // take the shadow time
    logic step;      // add the signed shadow offset
  } todStrobes_t;

endpackage

// File: rtl/tod_ctrl.sv
module tod_ctrl
  import tod_pkg::*;
#(
  parameter int SEC_W  = 48,
  parameter int NS_W   = 30,
  parameter int NOM_NS = 8,
  parameter int ADDR_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              regWrEn,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic [31:0]       regWrData,
  output logic [31:0]       regRdData,
  input  logic [SEC_W-1:0]  liveSec,
  input  logic [NS_W-1:0]   liveNs,
  output todStrobes_t       strobes,
  output logic [SEC_W-1:0]  loadSec,
  output logic [NS_W-1:0]   loadNs,
  output logic [31:0]       stepNs,
  output logic              runOn
);

  localparam int HI_W  = SEC_W - 32;
  localparam int IVL_W = 30;
  localparam int ACC_W = 32;
  localparam logic [ACC_W-1:0] STEP_PS = ACC_W'(NOM_NS * 1000);
  localparam logic [ACC_W-1:0] STEP_NS = ACC_W'(NOM_NS);

  logic             accDom, accSync;
  logic [2:0]       accAction;
  logic [HI_W-1:0]  shHi;
  logic [31:0]      shLo, shNs;
  logic             trimEn, trimDir, trimUnitNs;
  logic [IVL_W-1:0] trimIvl;
  logic [ACC_W-1:0] trimAcc;

  logic       accessWr;
  todAction_e wrAction;
  logic       doSave, doLoad, doStep;
  logic       tick, trimActive, fire;
  logic [ACC_W-1:0] accStep, accSum;

  always_comb begin
    accessWr   = regWrEn && (regAddr == ADDR_W'(OFF_ACCESS));
    wrAction   = todAction_e'(regWrData[5:3]);
    doSave     = accessWr && (wrAction == ACT_SAVE);
    doLoad     = accessWr && (wrAction == ACT_LOAD);
    doStep     = accessWr && (wrAction == ACT_STEP);
    tick       = runOn && !doLoad && !doStep;
    trimActive = trimEn && (trimIvl != '0);
    accStep    = trimUnitNs ? STEP_NS : STEP_PS;
    accSum     = trimAcc + accStep;
    fire       = tick && trimActive && (accSum >= ACC_W'(trimIvl));
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      accDom     <= 1'b0;
      accSync    <= 1'b0;
      accAction  <= '0;
      shHi       <= '0;
      shLo       <= '0;
      shNs       <= '0;
      runOn      <= 1'b0;
      trimEn     <= 1'b0;
      trimDir    <= 1'b0;
      trimUnitNs <= 1'b0;
      trimIvl    <= '0;
    end else if (regWrEn) begin
      unique case (regAddr)
        ADDR_W'(OFF_ACCESS): begin
          accDom    <= regWrData[0];
          accSync   <= regWrData[2];
          accAction <= regWrData[5:3];
          if (doSave) begin
            shHi <= liveSec[SEC_W-1:32];
            shLo <= liveSec[31:0];
            shNs <= 32'(liveNs);
          end
        end
        ADDR_W'(OFF_SEC_HI):   shHi <= regWrData[HI_W-1:0];
        ADDR_W'(OFF_SEC_LO):   shLo <= regWrData;
        ADDR_W'(OFF_NSEC):     shNs <= regWrData;
        ADDR_W'(OFF_RUN):      runOn <= regWrData[2];
        ADDR_W'(OFF_TRIM_CFG): begin
          trimEn  <= regWrData[0];
          trimDir <= regWrData[1];
        end
        ADDR_W'(OFF_TRIM_IVL): begin
          trimIvl    <= regWrData[IVL_W-1:0];
          trimUnitNs <= regWrData[30];
        end
        default: ;
      endcase
    end
  end

  // interval accumulator: counts elapsed time in the selected unit
  always_ff @(posedge clk) begin
    if (!rstN || !trimActive) trimAcc <= '0;
    else if (tick)            trimAcc <= fire ? accSum - ACC_W'(trimIvl) : accSum;
  end

  always_comb begin
    unique case (regAddr)
      ADDR_W'(OFF_ACCESS):   regRdData = {26'b0, accAction, accSync, 1'b0, accDom};
      ADDR_W'(OFF_SEC_HI):   regRdData = 32'(shHi);
      ADDR_W'(OFF_SEC_LO):   regRdData = shLo;
      ADDR_W'(OFF_NSEC):     regRdData = shNs;
      ADDR_W'(OFF_RUN):      regRdData = {29'b0, runOn, 2'b0};
      ADDR_W'(OFF_TRIM_CFG): regRdData = {30'b0, trimDir, trimEn};
      ADDR_W'(OFF_TRIM_IVL): regRdData = {1'b0, trimUnitNs, trimIvl};
      default:               regRdData = '0;
    endcase
  end

  always_comb begin
    strobes.tick     = tick;
    strobes.corrUp   = fire && !trimDir;
    strobes.corrDown = fire && trimDir;
    strobes.load     = doLoad;
    strobes.step     = doStep;
    loadSec          = {shHi, shLo};
    loadNs           = shNs[NS_W-1:0];
    stepNs           = shNs;
  end

endmodule

// File: rtl/tod_datapath.sv
module tod_datapath
  import tod_pkg::*;
#(
  parameter int SEC_W  = 48,
  parameter int NS_W   = 30,
  parameter int NOM_NS = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  todStrobes_t      strobes,
  input  logic [SEC_W-1:0] loadSec,
  input  logic [NS_W-1:0]  loadNs,
  input  logic [31:0]      stepNs,
  output logic [SEC_W-1:0] todSec,
  output logic [NS_W-1:0]  todNs
);

  localparam int TW = NS_W + 2;
  localparam int DW = ((NS_W > 32) ? NS_W : 32) + 2;
  localparam logic [TW-1:0]        BIL_T = TW'(NS_PER_SEC);
  localparam logic signed [DW-1:0] BIL_D = DW'(NS_PER_SEC);

  logic [TW-1:0]        advance, tickSum;
  logic signed [DW-1:0] stepSum;
  logic [SEC_W-1:0]     secNext;
  logic [NS_W-1:0]      nsNext;

  always_comb begin
    advance = TW'(NOM_NS) + TW'(strobes.corrUp) - TW'(strobes.corrDown);
    tickSum = TW'(todNs) + advance;
    stepSum = $signed({{(DW-NS_W){1'b0}}, todNs}) + $signed({{(DW-32){stepNs[31]}}, stepNs});
    secNext = todSec;
    nsNext  = todNs;
    if (strobes.load) begin
      secNext = loadSec;
      nsNext  = loadNs;
    end else if (strobes.step) begin
      if (stepSum < 0) begin
        secNext = todSec - 1'b1;
        nsNext  = NS_W'(stepSum + BIL_D);
      end else if (stepSum >= BIL_D) begin
        secNext = todSec + 1'b1;
        nsNext  = NS_W'(stepSum - BIL_D);
      end else begin
        nsNext  = NS_W'(stepSum);
      end
    end else if (strobes.tick) begin
      if (tickSum >= BIL_T) begin
        secNext = todSec + 1'b1;
        nsNext  = NS_W'(tickSum - BIL_T);
      end else begin
        nsNext  = NS_W'(tickSum);
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      todSec <= '0;
      todNs  <= '0;
    end else begin
      todSec <= secNext;
      todNs  <= nsNext;
    end
  end

endmodule

// File: rtl/tod_clock.sv
module tod_clock
  import tod_pkg::*;
#(
  parameter int SEC_W  = 48,
  parameter int NS_W   = 30,
  parameter int NOM_NS = 8,
  parameter int ADDR_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              regWrEn,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic [31:0]       regWrData,
  output logic [31:0]       regRdData,
  output logic [SEC_W-1:0]  todSec,
  output logic [NS_W-1:0]   todNs
);

  todStrobes_t      strobes;
  logic [SEC_W-1:0] loadSec;
  logic [NS_W-1:0]  loadNs;
  logic [31:0]      stepNs;
  logic             runOn;

  tod_ctrl #(.SEC_W(SEC_W), .NS_W(NS_W), .NOM_NS(NOM_NS), .ADDR_W(ADDR_W)) i_ctrl (
    .clk(clk), .rstN(rstN), .regWrEn(regWrEn), .regAddr(regAddr),
    .regWrData(regWrData), .regRdData(regRdData), .liveSec(todSec), .liveNs(todNs),
    .strobes(strobes), .loadSec(loadSec), .loadNs(loadNs), .stepNs(stepNs), .runOn(runOn)
  );

  tod_datapath #(.SEC_W(SEC_W), .NS_W(NS_W), .NOM_NS(NOM_NS)) i_dp (
    .clk(clk), .rstN(rstN), .strobes(strobes), .loadSec(loadSec), .loadNs(loadNs),
    .stepNs(stepNs), .todSec(todSec), .todNs(todNs)
  );

endmodule

// File: rtl/tod_clock_chk.sv
module tod_clock_chk #(
  parameter int SEC_W  = 48,
  parameter int NS_W   = 30,
  parameter int ADDR_W = 8
) (
  input logic              clk,
  input logic              rstN,
  input logic              regWrEn,
  input logic [ADDR_W-1:0] regAddr,
  input logic [31:0]       regWrData,
  input logic [SEC_W-1:0]  todSec,
  input logic [NS_W-1:0]   todNs,
  input logic              runOn,
  input logic [SEC_W-1:0]  loadSec,
  input logic [NS_W-1:0]   loadNs
);

  assert_ns_range_R2: assert property (@(posedge clk) disable iff (!rstN)
    todNs < NS_W'(1_000_000_000));

  assert_sec_step_R2: assert property (@(posedge clk) disable iff (!rstN)
    !regWrEn |=> (todSec == $past(todSec)) || (todSec == $past(todSec) + 1'b1));

  assert_hold_R3: assert property (@(posedge clk) disable iff (!rstN)
    (!runOn && !regWrEn) |=> $stable(todSec) && $stable(todNs));

  assert_load_R5: assert property (@(posedge clk) disable iff (!rstN)
    (regWrEn && regAddr == ADDR_W'(8'h00) && regWrData[5:3] == 3'd1)
      |=> (todSec == $past(loadSec)) && (todNs == $past(loadNs)));

endmodule

bind tod_clock tod_clock_chk #(.SEC_W(SEC_W), .NS_W(NS_W), .ADDR_W(ADDR_W)) i_chk (
  .clk(clk), .rstN(rstN), .regWrEn(regWrEn), .regAddr(regAddr), .regWrData(regWrData),
  .todSec(todSec), .todNs(todNs), .runOn(runOn), .loadSec(loadSec), .loadNs(loadNs)
);

// File: tb/test_tod_clock.sv
`timescale 1ns/1ps
module test_tod_clock;

  localparam int     NOM = 8;
  localparam longint BIL = 1_000_000_000;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        regWrEn = 1'b0;
  logic [7:0]  regAddr = '0;
  logic [31:0] regWrData = '0;
  logic [31:0] regRdData;
  logic [47:0] todSec;
  logic [29:0] todNs;
  int checks = 0;
  int errors = 0;

  tod_clock i_tod_clock (
    .clk(clk), .rstN(rstN), .regWrEn(regWrEn), .regAddr(regAddr),
    .regWrData(regWrData), .regRdData(regRdData), .todSec(todSec), .todNs(todNs)
  );

  always #5 clk = ~clk;

  initial begin
    #1_500_000;
    errors++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    regAddr = a; regWrData = d; regWrEn = 1'b1;
    @(posedge clk);
    #1 regWrEn = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    regAddr = a;
    #1 d = regRdData;
  endtask

  task automatic checkVal(input string tag, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic checkTime(input string tag, input longint s, input longint n);
    checkVal({tag, " sec"}, longint'(todSec), s);
    checkVal({tag, " ns"}, longint'(todNs), n);
  endtask

  function automatic void normTime(input longint s0, input longint n0, input longint d,
                                   output longint s, output longint n);
    s = s0; n = n0 + d;
    while (n >= BIL) begin n -= BIL; s++; end
    while (n < 0)    begin n += BIL; s--; end
  endfunction

  task automatic loadTime(input longint s, input longint n);
    wr(8'h04, 32'(s >> 32));
    wr(8'h08, 32'(s));
    wr(8'h0C, 32'(n));
    wr(8'h00, 32'(1 << 3));
  endtask

  // configure trim, load, count n cycles, stop; check against closed form
  task automatic runTrim(input string tag, input longint s0, input longint n0, input bit unitNs,
                         input bit dir, input bit en, input int ivl, input int n);
    longint stepV, corr, es, en2;
    wr(8'hA4, 32'h0);
    wr(8'hA8, {1'b0, unitNs, 30'(ivl)});
    wr(8'hA4, {30'b0, dir, en});
    loadTime(s0, n0);
    wr(8'hA0, 32'h4);
    if (n > 1) idle(n - 1);
    wr(8'hA0, 32'h0);
    stepV = unitNs ? NOM : NOM * 1000;
    corr  = (en && ivl != 0) ? (longint'(n) * stepV) / ivl : 0;
    normTime(s0, n0, longint'(n) * NOM + (dir ? -corr : corr), es, en2);
    checkTime(tag, es, en2);
  endtask

  initial begin
    logic [31:0] d;
    longint es, en2;
    void'($urandom(32'd4242));
    repeat (3) @(posedge clk);
    #1 rstN = 1'b1;

    // R1 reset state
    checkTime("R1 reset time", 0, 0);
    foreach (d[i]) begin end
    for (int i = 0; i < 7; i++) begin
      logic [7:0] offs [7] = '{8'h00, 8'h04, 8'h08, 8'h0C, 8'hA0, 8'hA4, 8'hA8};
      rd(offs[i], d);
      checkVal("R1 register reset", d, 0);
    end

    // R8 access word readback, R7 idle/unused actions
    wr(8'h00, 32'hFFFF_FFC5);
    rd(8'h00, d); checkVal("R8 readback masks", d, 32'h05);
    wr(8'h00, 32'h0000_003D);
    rd(8'h00, d); checkVal("R8 readback action 7", d, 32'h3D);
    checkTime("R7 action 7 no effect", 0, 0);

    // R5 load
    loadTime(48'h1_0000_0010, 999_999_990);
    checkTime("R5 load", 48'h1_0000_0010, 999_999_990);

    // R2 counting with wrap (6 counted cycles)
    wr(8'hA0, 32'h4); idle(5); wr(8'hA0, 32'h0);
    checkTime("R2 count and wrap", 48'h1_0000_0011, 38);

    // R3 other run bits do nothing
    wr(8'hA0, 32'hFFFF_FFFB); idle(10);
    checkTime("R3 held with run clear", 48'h1_0000_0011, 38);

    // R4 snapshot while stopped
    wr(8'h00, 32'(2 << 3));
    rd(8'h04, d); checkVal("R4 save sec hi", d, 1);
    rd(8'h08, d); checkVal("R4 save sec lo", d, 32'h11);
    rd(8'h0C, d); checkVal("R4 save ns", d, 38);

    // R7 other codes leave shadows and time alone
    wr(8'h08, 32'hABCD);
    wr(8'h00, 32'(3 << 3)); wr(8'h00, 32'(5 << 3)); wr(8'h00, 32'(6 << 3));
    rd(8'h08, d); checkVal("R7 shadow untouched", d, 32'hABCD);
    checkTime("R7 time untouched", 48'h1_0000_0011, 38);

    // R6 step backward with borrow, then forward with carry
    loadTime(5, 100);
    wr(8'h0C, 32'hFFFF_FF38);        // -200
    wr(8'h00, 32'(4 << 3));
    checkTime("R6 step negative", 4, 999_999_900);
    wr(8'h0C, 32'd150);
    wr(8'h00, 32'(4 << 3));
    checkTime("R6 step positive carry", 5, 50);
    wr(8'h0C, 32'd499_999_999);
    wr(8'h00, 32'(4 << 3));
    checkTime("R6 step half second", 5, 500_000_049);

    // R4 snapshot while counting: snapshot sees 3 cycles, live sees 5
    loadTime(20, 1000);
    wr(8'hA0, 32'h4); idle(3); wr(8'h00, 32'(2 << 3)); wr(8'hA0, 32'h0);
    rd(8'h0C, d); checkVal("R4 running snapshot ns", d, 1024);
    rd(8'h08, d); checkVal("R4 running snapshot sec", d, 20);
    checkTime("R4 live unaffected", 20, 1040);

    // R10 correction on the wrap edge
    runTrim("R10 trim on wrap", 7, BIL - 9, 1'b1, 1'b0, 1'b1, 9, 2);
    runTrim("R10 slow trim on wrap", 9, BIL - 16, 1'b1, 1'b1, 1'b1, 9, 3);

    // R11 disabled trim, zero interval
    runTrim("R11 trim disabled", 3, 0, 1'b0, 1'b0, 1'b0, 9000, 50);
    runTrim("R11 zero interval", 3, 0, 1'b0, 1'b0, 1'b1, 0, 50);

    // R9 directed in both units
    runTrim("R9 ps fast", 1, 0, 1'b0, 1'b0, 1'b1, 20000, 7);
    runTrim("R9 ns slow", 1, 500, 1'b1, 1'b1, 1'b1, 40, 100);

    // R9 random runs near the boundary
    for (int k = 0; k < 24; k++) begin
      bit unitNs = 1'($urandom);
      bit dir    = 1'($urandom);
      int ivl    = unitNs ? 9 + int'($urandom % 200) : 8001 + int'($urandom % 200000);
      int n      = 1 + int'($urandom % 300);
      longint n0 = ($urandom % 2) ? BIL - 1 - longint'($urandom % 3000) : longint'($urandom % 1000);
      runTrim("R9 random trim", longint'($urandom % 1000), n0, unitNs, dir, 1'b1, ivl, n);
    end

    normTime(0, 0, 0, es, en2);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule